// File: doc/BRIEF.md
# Multirate Link Reconfiguration Sequencer

This block is the control engine that moves one serial link channel through an ordered list of line-rate profiles. Each profile is a small numeric ID. For every entry in the list, the block puts the transmit path and then the receive path into reset, waiting for each acknowledge. It then runs a fixed four-step handshake with an external reconfiguration engine and records the new rate and FEC setting. After that it releases transmit reset and then receive reset, each gated by readiness from the link. The last step is a latency measurement run, whose checker verdict it samples.

Some steps apply only to certain profiles. A receive PCS-ready check runs only for the profiles that need it, which are the two highest rates. For the FEC profile, a word-alignment correction is loaded into the latency counter before the measurement starts. Each wait is bounded by a common programmable timeout. On any failure a sticky error flag is set, and the final pass output is its inverse. The transceiver, the reconfiguration engine and the latency counter all sit outside the block.

States: `S_IDLE`, `S_PLL_WAIT`, `S_ENG_RST`, `S_ENG_REL`, `S_TXR_WAIT`, `S_RXR_WAIT`, `S_CFG_RDY`, `S_CFG_REQ`, `S_CFG_DONE`, `S_APPLY`, `S_TXRDY_WAIT`, `S_RXRDY_WAIT`, `S_PCS_WAIT`, `S_LAT_LOAD`, `S_LAT_START`, `S_HF_WAIT`, `S_RT_WAIT`, `S_MV_WAIT`, `S_DONE`.

Transitions:
- Start: `S_IDLE` or `S_DONE` on `start_i` goes to `S_PLL_WAIT`.
- Engine reset: lock goes to `S_ENG_RST`, then `S_ENG_REL`, then `S_TXR_WAIT`.
- Resets and handshake: transmit ack goes to `S_RXR_WAIT`, receive ack to `S_CFG_RDY`, ready to `S_CFG_REQ`, ack to `S_CFG_DONE`, and done to `S_APPLY`, then `S_TXRDY_WAIT`.
- Readiness: `tx_ready_i` goes to `S_RXRDY_WAIT`. `rx_ready_i` goes to `S_PCS_WAIT`, `S_LAT_LOAD` or `S_LAT_START`, depending on the profile. PCS ready goes to `S_LAT_LOAD` or `S_LAT_START`.
- Measurement: `S_LAT_LOAD` goes to `S_LAT_START`, then `S_HF_WAIT`. Sync goes to `S_RT_WAIT`, count-done to `S_MV_WAIT`, and measurement-valid to `S_TXR_WAIT` (next profile) or `S_DONE` (last profile).
- Timeout: every wait state goes to `S_DONE` when it times out.

Top module: `link_reconfig_seq`

## Requirements
- R1: After `start_i`, `busy_o` is high and nothing else happens until `pll_lock_i` is high. Then `eng_rst_o` is high for exactly one cycle, followed by one low cycle, before any link reset.
- R2: Per profile, `tx_rst_o` rises first. `rx_rst_o` rises only after `tx_rst_ack_i` was seen, and the block waits for `rx_rst_ack_i`.
- R3: The block waits for `eng_ready_i`, then raises `eng_req_o` with `eng_prof_o` equal to the target profile ID, held stable while the request is high. It drops the request once `eng_ack_i` is seen, then waits for `eng_done_i`.
- R4: After the done, `cur_prof_o` takes the profile ID and `fec_en_o` takes the profile's FEC flag. `tx_rst_o` is released first. `rx_rst_o` is released only after `tx_ready_i`, and the block then waits for `rx_ready_i`.
- R5: `rx_pcs_ready_i` is waited for only for profile IDs 0 and 1. For IDs 2 and above it is ignored.
- R6: Only for the FEC profile (ID 0), `lat_load_o` pulses for one cycle with `lat_wa_o` = `WA_VALUE`, in the cycle just before `lat_start_o`.
- R7: `lat_start_o` pulses for one cycle. The block then waits for `hf_sync_i`, then `rt_done_i`, then `meas_valid_i`, and samples `chk_pass_i` in the `meas_valid_i` cycle. A low verdict sets the error flag, and the sequence goes on to the next profile.
- R8: Profiles are visited in list order, index 0 first. The default list is 1, 2, 3, 4, 0. Out of reset, `cur_prof_o` = 0 and `fec_en_o` = 1.
- R9: If any wait state stays unsatisfied for more than `tmo_limit_i` cycles, `err_o` is set and the block goes to done, releasing both link resets.
- R10: At done, `busy_o` = 0, `done_o` = 1 and `pass_o` = !`err_o`. A new `start_i` clears the error flag and restarts from index 0.
- R11: After reset, `busy_o`, `done_o`, `pass_o`, `err_o`, `tx_rst_o`, `rx_rst_o`, `eng_req_o` and `eng_rst_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a sequence run |
| tmo_limit_i | input | TO_W | Maximum cycles allowed in one wait state |
| pll_lock_i | input | 1 | Reference PLL locked |
| eng_rst_o | output | 1 | Reconfiguration engine reset |
| eng_ready_i | input | 1 | Engine ready for a request |
| eng_req_o | output | 1 | Reconfiguration request |
| eng_prof_o | output | PID_W | Target profile ID |
| eng_ack_i | input | 1 | Request acknowledged |
| eng_done_i | input | 1 | Configuration complete |
| tx_rst_o | output | 1 | Transmit path reset |
| tx_rst_ack_i | input | 1 | Transmit path is in reset |
| rx_rst_o | output | 1 | Receive path reset |
| rx_rst_ack_i | input | 1 | Receive path is in reset |
| tx_ready_i | input | 1 | Transmit path ready |
| rx_ready_i | input | 1 | Receive path ready |
| rx_pcs_ready_i | input | 1 | Receive PCS ready |
| lat_load_o | output | 1 | Load alignment correction into latency counter |
| lat_wa_o | output | WA_W | Alignment correction value |
| lat_start_o | output | 1 | Start latency measurement |
| hf_sync_i | input | 1 | Hyperframe sync reached |
| rt_done_i | input | 1 | Round-trip count finished |
| meas_valid_i | input | 1 | Measurement result valid |
| chk_pass_i | input | 1 | Traffic checker verdict |
| cur_prof_o | output | PID_W | Currently applied profile ID |
| fec_en_o | output | 1 | FEC enabled for current profile |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |
| pass_o | output | 1 | Finished without error |
| err_o | output | 1 | Sticky error flag |

## Verification
Some ordering rules hold cycle by cycle, and the assertions check them on every cycle:
- the engine reset lasts one cycle and follows lock;
- receive reset rises only after the transmit acknowledge;
- a request rises only after engine ready and keeps a stable profile ID;
- each reset release follows its readiness input;
- the alignment load comes only on the FEC profile and just ahead of the start pulse;
- the error flag clears only on a start.

Other behaviour spans a whole run, and only the bench scenarios can show it. This covers the list order and the request IDs, the rate and FEC values at each measurement start, and the PCS check skipped on low-rate profiles. It also covers a failing checker verdict that leaves the rest of the list to run, and timeouts that end a run early with the resets released.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    localparam int PID_W = 3;
    typedef logic [PID_W-1:0] pid_t;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PLL_WAIT,
        S_ENG_RST,
        S_ENG_REL,
        S_TXR_WAIT,
        S_RXR_WAIT,
        S_CFG_RDY,
        S_CFG_REQ,
        S_CFG_DONE,
        S_APPLY,
        S_TXRDY_WAIT,
        S_RXRDY_WAIT,
        S_PCS_WAIT,
        S_LAT_LOAD,
        S_LAT_START,
        S_HF_WAIT,
        S_RT_WAIT,
        S_MV_WAIT,
        S_DONE
    } seq_state_t;

endpackage

// File: rtl/lrs_profile_table.sv
module lrs_profile_table
    import lrs_pkg::*;
#(
    parameter int N_PROF = 5,
    parameter int IDX_W = 3,
    parameter logic [N_PROF*PID_W-1:0] SEQ = '0,
    parameter int FEC_ID = 0,
    parameter int PCS_MAX_ID = 1
) (
    input  logic [IDX_W-1:0] idx_i,
    output pid_t             prof_id_o,
    output logic             prof_fec_o,
    output logic             prof_pcs_o,
    output logic             last_o
);

    pid_t ids [N_PROF];

    for (genvar g = 0; g < N_PROF; g++) begin : g_entry
        assign ids[g] = SEQ[g*PID_W +: PID_W];
    end

    assign prof_id_o  = ids[idx_i];
    assign prof_fec_o = (prof_id_o == PID_W'(FEC_ID));
    assign prof_pcs_o = (prof_id_o <= PID_W'(PCS_MAX_ID));
    assign last_o     = (idx_i == IDX_W'(N_PROF - 1));

endmodule

// File: rtl/lrs_wait_timer.sv
module lrs_wait_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            en_i,
    input  logic [TO_W-1:0] limit_i,
    output logic            expired_o
);

    logic [TO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = en_i && (cnt_q >= limit_i);

endmodule

// File: rtl/lrs_fsm.sv
module lrs_fsm
    import lrs_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int PWRUP_ID = 0,
    parameter int FEC_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pll_lock_i,
    input  logic             eng_ready_i,
    input  logic             eng_ack_i,
    input  logic             eng_done_i,
    input  logic             tx_rst_ack_i,
    input  logic             rx_rst_ack_i,
    input  logic             tx_ready_i,
    input  logic             rx_ready_i,
    input  logic             rx_pcs_ready_i,
    input  logic             hf_sync_i,
    input  logic             rt_done_i,
    input  logic             meas_valid_i,
    input  logic             chk_pass_i,
    input  pid_t             prof_id_i,
    input  logic             prof_fec_i,
    input  logic             prof_pcs_i,
    input  logic             last_i,
    input  logic             tmo_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             tmr_clr_o,
    output logic             tmr_en_o,
    output logic             eng_rst_o,
    output logic             eng_req_o,
    output logic             tx_rst_o,
    output logic             rx_rst_o,
    output logic             lat_load_o,
    output logic             lat_start_o,
    output pid_t             cur_prof_o,
    output logic             fec_en_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             err_o
);

    seq_state_t st, nxt, tgt;
    logic       cond, is_wait, tmo_hit, advance;
    logic [IDX_W-1:0] idx_q;
    pid_t       cur_q;
    logic       fec_q, err_q;

    // transition condition and target of each state
    always_comb begin
        cond    = 1'b1;
        tgt     = st;
        is_wait = 1'b0;
        unique case (st)
            S_IDLE, S_DONE: begin
                cond = start_i;
                tgt  = S_PLL_WAIT;
            end
            S_PLL_WAIT: begin
                is_wait = 1'b1;
                cond    = pll_lock_i;
                tgt     = S_ENG_RST;
            end
            S_ENG_RST:  tgt = S_ENG_REL;
            S_ENG_REL:  tgt = S_TXR_WAIT;
            S_TXR_WAIT: begin
                is_wait = 1'b1;
                cond    = tx_rst_ack_i;
                tgt     = S_RXR_WAIT;
            end
            S_RXR_WAIT: begin
                is_wait = 1'b1;
                cond    = rx_rst_ack_i;
                tgt     = S_CFG_RDY;
            end
            S_CFG_RDY: begin
                is_wait = 1'b1;
                cond    = eng_ready_i;
                tgt     = S_CFG_REQ;
            end
            S_CFG_REQ: begin
                is_wait = 1'b1;
                cond    = eng_ack_i;
                tgt     = S_CFG_DONE;
            end
            S_CFG_DONE: begin
                is_wait = 1'b1;
                cond    = eng_done_i;
                tgt     = S_APPLY;
            end
            S_APPLY:    tgt = S_TXRDY_WAIT;
            S_TXRDY_WAIT: begin
                is_wait = 1'b1;
                cond    = tx_ready_i;
                tgt     = S_RXRDY_WAIT;
            end
            S_RXRDY_WAIT: begin
                is_wait = 1'b1;
                cond    = rx_ready_i;
                if (prof_pcs_i)      tgt = S_PCS_WAIT;
                else if (prof_fec_i) tgt = S_LAT_LOAD;
                else                 tgt = S_LAT_START;
            end
            S_PCS_WAIT: begin
                is_wait = 1'b1;
                cond    = rx_pcs_ready_i;
                tgt     = prof_fec_i ? S_LAT_LOAD : S_LAT_START;
            end
            S_LAT_LOAD:  tgt = S_LAT_START;
            S_LAT_START: tgt = S_HF_WAIT;
            S_HF_WAIT: begin
                is_wait = 1'b1;
                cond    = hf_sync_i;
                tgt     = S_RT_WAIT;
            end
            S_RT_WAIT: begin
                is_wait = 1'b1;
                cond    = rt_done_i;
                tgt     = S_MV_WAIT;
            end
            S_MV_WAIT: begin
                is_wait = 1'b1;
                cond    = meas_valid_i;
                tgt     = last_i ? S_DONE : S_TXR_WAIT;
            end
            default: tgt = S_IDLE;
        endcase
    end

    assign tmo_hit = is_wait && !cond && tmo_i;
    assign advance = (st == S_MV_WAIT) && meas_valid_i;

    always_comb begin
        if (cond)         nxt = tgt;
        else if (tmo_hit) nxt = S_DONE;
        else              nxt = st;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // profile index, applied settings and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            err_q <= 1'b0;
            cur_q <= PID_W'(PWRUP_ID);
            fec_q <= (PWRUP_ID == FEC_ID);
        end else begin
            if ((st == S_IDLE || st == S_DONE) && start_i) begin
                idx_q <= '0;
                err_q <= 1'b0;
            end
            if (tmo_hit) err_q <= 1'b1;
            if (st == S_APPLY) begin
                cur_q <= prof_id_i;
                fec_q <= prof_fec_i;
            end
            if (advance) begin
                if (!chk_pass_i) err_q <= 1'b1;
                if (!last_i)     idx_q <= idx_q + 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        eng_rst_o   = (st == S_ENG_RST);
        eng_req_o   = (st == S_CFG_REQ);
        lat_load_o  = (st == S_LAT_LOAD);
        lat_start_o = (st == S_LAT_START);
        busy_o      = (st != S_IDLE) && (st != S_DONE);
        done_o      = (st == S_DONE);
        tx_rst_o    = 1'b0;
        rx_rst_o    = 1'b0;
        unique case (st)
            S_TXR_WAIT:                 tx_rst_o = 1'b1;
            S_RXR_WAIT, S_CFG_RDY,
            S_CFG_REQ, S_CFG_DONE: begin
                tx_rst_o = 1'b1;
                rx_rst_o = 1'b1;
            end
            S_APPLY, S_TXRDY_WAIT:      rx_rst_o = 1'b1;
            default: ;
        endcase
    end

    assign pass_o     = done_o && !err_q;
    assign err_o      = err_q;
    assign idx_o      = idx_q;
    assign cur_prof_o = cur_q;
    assign fec_en_o   = fec_q;
    assign tmr_clr_o  = (nxt != st);
    assign tmr_en_o   = is_wait;

endmodule

// File: rtl/link_reconfig_seq.sv
module link_reconfig_seq
    import lrs_pkg::*;
#(
    parameter int N_PROF = 5,
    parameter logic [N_PROF*PID_W-1:0] SEQ = {3'd0, 3'd4, 3'd3, 3'd2, 3'd1},
    parameter int PWRUP_ID = 0,
    parameter int FEC_ID = 0,
    parameter int PCS_MAX_ID = 1,
    parameter int TO_W = 16,
    parameter int WA_W = 16,
    parameter logic [WA_W-1:0] WA_VALUE = 16'h0123
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [TO_W-1:0] tmo_limit_i,
    input  logic            pll_lock_i,
    output logic            eng_rst_o,
    input  logic            eng_ready_i,
    output logic            eng_req_o,
    output logic [PID_W-1:0] eng_prof_o,
    input  logic            eng_ack_i,
    input  logic            eng_done_i,
    output logic            tx_rst_o,
    input  logic            tx_rst_ack_i,
    output logic            rx_rst_o,
    input  logic            rx_rst_ack_i,
    input  logic            tx_ready_i,
    input  logic            rx_ready_i,
    input  logic            rx_pcs_ready_i,
    output logic            lat_load_o,
    output logic [WA_W-1:0] lat_wa_o,
    output logic            lat_start_o,
    input  logic            hf_sync_i,
    input  logic            rt_done_i,
    input  logic            meas_valid_i,
    input  logic            chk_pass_i,
    output logic [PID_W-1:0] cur_prof_o,
    output logic            fec_en_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            pass_o,
    output logic            err_o
);

    localparam int IDX_W = (N_PROF > 1) ? $clog2(N_PROF) : 1;

    logic [IDX_W-1:0] idx;
    pid_t             prof_id;
    logic             prof_fec, prof_pcs, last;
    logic             tmr_clr, tmr_en, tmo;

    lrs_profile_table #(
        .N_PROF(N_PROF), .IDX_W(IDX_W), .SEQ(SEQ),
        .FEC_ID(FEC_ID), .PCS_MAX_ID(PCS_MAX_ID)
    ) u_table (
        .idx_i(idx), .prof_id_o(prof_id), .prof_fec_o(prof_fec),
        .prof_pcs_o(prof_pcs), .last_o(last)
    );

    lrs_wait_timer #(.TO_W(TO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .en_i(tmr_en),
        .limit_i(tmo_limit_i), .expired_o(tmo)
    );

    lrs_fsm #(.IDX_W(IDX_W), .PWRUP_ID(PWRUP_ID), .FEC_ID(FEC_ID)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .pll_lock_i(pll_lock_i), .eng_ready_i(eng_ready_i),
        .eng_ack_i(eng_ack_i), .eng_done_i(eng_done_i),
        .tx_rst_ack_i(tx_rst_ack_i), .rx_rst_ack_i(rx_rst_ack_i),
        .tx_ready_i(tx_ready_i), .rx_ready_i(rx_ready_i),
        .rx_pcs_ready_i(rx_pcs_ready_i), .hf_sync_i(hf_sync_i),
        .rt_done_i(rt_done_i), .meas_valid_i(meas_valid_i),
        .chk_pass_i(chk_pass_i), .prof_id_i(prof_id),
        .prof_fec_i(prof_fec), .prof_pcs_i(prof_pcs), .last_i(last),
        .tmo_i(tmo), .idx_o(idx), .tmr_clr_o(tmr_clr), .tmr_en_o(tmr_en),
        .eng_rst_o(eng_rst_o), .eng_req_o(eng_req_o),
        .tx_rst_o(tx_rst_o), .rx_rst_o(rx_rst_o),
        .lat_load_o(lat_load_o), .lat_start_o(lat_start_o),
        .cur_prof_o(cur_prof_o), .fec_en_o(fec_en_o),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .err_o(err_o)
    );

    assign eng_prof_o = prof_id;
    assign lat_wa_o   = WA_VALUE;

endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
    parameter int PID_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             pll_lock_i,
    input logic             eng_rst_o,
    input logic             eng_ready_i,
    input logic             eng_req_o,
    input logic [PID_W-1:0] eng_prof_o,
    input logic             eng_ack_i,
    input logic             eng_done_i,
    input logic             tx_rst_o,
    input logic             tx_rst_ack_i,
    input logic             rx_rst_o,
    input logic             tx_ready_i,
    input logic             lat_load_o,
    input logic             lat_start_o,
    input logic             fec_en_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             pass_o,
    input logic             err_o
);

    p_engrst_after_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_rst_o) |-> $past(pll_lock_i));
    p_engrst_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rst_o |=> !eng_rst_o);
    p_rx_after_txack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_rst_o) |-> ($past(tx_rst_ack_i) && tx_rst_o));
    p_req_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req_o) |-> $past(eng_ready_i));
    p_req_id_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req_o && $past(eng_req_o)) |-> $stable(eng_prof_o));
    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req_o && !eng_ack_i) |=> (eng_req_o || done_o));
    p_tx_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_rst_o) |-> (done_o || ($past(eng_done_i) && rx_rst_o)));
    p_rx_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_rst_o) |-> (done_o || ($past(tx_ready_i) && !tx_rst_o)));
    p_load_fec_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lat_load_o |-> fec_en_o);
    p_load_then_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lat_load_o |=> lat_start_o);
    p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lat_start_o |=> !lat_start_o);
    p_err_clear_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_o) |-> $past(start_i));
    p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
    p_pass_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> (done_o && !err_o));

endmodule

bind link_reconfig_seq lrs_checker #(.PID_W(lrs_pkg::PID_W)) u_lrs_checker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pll_lock_i(pll_lock_i),
    .eng_rst_o(eng_rst_o), .eng_ready_i(eng_ready_i), .eng_req_o(eng_req_o),
    .eng_prof_o(eng_prof_o), .eng_ack_i(eng_ack_i), .eng_done_i(eng_done_i),
    .tx_rst_o(tx_rst_o), .tx_rst_ack_i(tx_rst_ack_i), .rx_rst_o(rx_rst_o),
    .tx_ready_i(tx_ready_i), .lat_load_o(lat_load_o),
    .lat_start_o(lat_start_o), .fec_en_o(fec_en_o), .busy_o(busy_o),
    .done_o(done_o), .pass_o(pass_o), .err_o(err_o)
);

// File: tb/tb_link_reconfig_seq.sv
module tb_link_reconfig_seq;

    localparam int PID_W = 3;
    localparam int WA_W  = 16;
    localparam int TO_W  = 16;
    localparam logic [WA_W-1:0] WA = 16'h0123;
    localparam int LIST [5] = '{1, 2, 3, 4, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic start_i = 0, pll_lock_i = 0;
    logic [TO_W-1:0] tmo_limit_i = 16'd40;
    logic eng_rst_o, eng_req_o, tx_rst_o, rx_rst_o, lat_load_o, lat_start_o;
    logic [PID_W-1:0] eng_prof_o, cur_prof_o;
    logic [WA_W-1:0] lat_wa_o;
    logic fec_en_o, busy_o, done_o, pass_o, err_o;
    logic eng_ready_i = 0, eng_ack_i = 0, eng_done_i = 0;
    logic tx_rst_ack_i = 0, rx_rst_ack_i = 0, tx_ready_i = 0, rx_ready_i = 0;
    logic rx_pcs_ready_i = 0, hf_sync_i = 0, rt_done_i = 0, meas_valid_i = 0;
    logic chk_pass_i = 0;

    link_reconfig_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tmo_limit_i(tmo_limit_i),
        .pll_lock_i(pll_lock_i), .eng_rst_o(eng_rst_o), .eng_ready_i(eng_ready_i),
        .eng_req_o(eng_req_o), .eng_prof_o(eng_prof_o), .eng_ack_i(eng_ack_i),
        .eng_done_i(eng_done_i), .tx_rst_o(tx_rst_o), .tx_rst_ack_i(tx_rst_ack_i),
        .rx_rst_o(rx_rst_o), .rx_rst_ack_i(rx_rst_ack_i), .tx_ready_i(tx_ready_i),
        .rx_ready_i(rx_ready_i), .rx_pcs_ready_i(rx_pcs_ready_i),
        .lat_load_o(lat_load_o), .lat_wa_o(lat_wa_o), .lat_start_o(lat_start_o),
        .hf_sync_i(hf_sync_i), .rt_done_i(rt_done_i), .meas_valid_i(meas_valid_i),
        .chk_pass_i(chk_pass_i), .cur_prof_o(cur_prof_o), .fec_en_o(fec_en_o),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .err_o(err_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // responder knobs
    logic blk_rxack = 0;
    logic pcs_en    = 1;
    int   fail_id   = 7;
    logic eng_seen  = 0;

    // link, engine and latency-counter responders
    always @(negedge clk) begin
        eng_ready_i  <= 1'b1;
        tx_rst_ack_i <= tx_rst_o;
        rx_rst_ack_i <= rx_rst_o && !blk_rxack;
        eng_ack_i    <= eng_req_o;
        if (!tx_rst_o) begin
            eng_seen   <= 1'b0;
            eng_done_i <= 1'b0;
        end else begin
            if (eng_ack_i) eng_seen <= 1'b1;
            eng_done_i <= eng_seen;
        end
        tx_ready_i     <= !tx_rst_o;
        rx_ready_i     <= !rx_rst_o;
        rx_pcs_ready_i <= !rx_rst_o && pcs_en && (eng_prof_o <= 3'd1);
        if (tx_rst_o || !busy_o) begin
            hf_sync_i <= 0; rt_done_i <= 0; meas_valid_i <= 0;
        end else begin
            if (lat_start_o) hf_sync_i <= 1;
            if (hf_sync_i)   rt_done_i <= 1;
            if (rt_done_i)   meas_valid_i <= 1;
        end
        chk_pass_i <= (int'(eng_prof_o) != fail_id);
    end

    // scoreboard
    typedef struct packed {
        logic [1:0]  kind;   // 0 request, 1 load, 2 start
        logic [15:0] val;
    } ev_t;
    ev_t exp_q [$];

    task automatic push_run(input int stop_after_req);
        for (int i = 0; i < 5; i++) begin
            exp_q.push_back({2'd0, 16'(LIST[i])});
            if (stop_after_req == i) return;
            if (LIST[i] == 0) exp_q.push_back({2'd1, WA});
            exp_q.push_back({2'd2, 16'({(LIST[i] == 0), 3'(LIST[i])})});
        end
    endtask

    logic req_prev = 0;
    int   engrst_cycles = 0;
    always @(negedge clk) begin
        ev_t e;
        if (rst_n) begin
            if (eng_rst_o) engrst_cycles++;
            if (eng_req_o && !req_prev) begin
                if (exp_q.size() == 0) check(0, "R8 unexpected request", int'(eng_prof_o), -1);
                else begin
                    e = exp_q.pop_front();
                    check(e.kind == 0 && 16'(eng_prof_o) == e.val,
                          "R3/R8 request id", int'(eng_prof_o), int'(e.val));
                end
            end
            if (lat_load_o) begin
                if (exp_q.size() == 0) check(0, "R6 unexpected load", int'(cur_prof_o), -1);
                else begin
                    e = exp_q.pop_front();
                    check(e.kind == 1 && lat_wa_o == e.val, "R6 load value",
                          int'(lat_wa_o), int'(e.val));
                end
            end
            if (lat_start_o) begin
                if (exp_q.size() == 0) check(0, "R7 unexpected start", int'(cur_prof_o), -1);
                else begin
                    e = exp_q.pop_front();
                    check(e.kind == 2 && 16'({fec_en_o, cur_prof_o}) == e.val,
                          "R4 rate/fec at start", int'({fec_en_o, cur_prof_o}), int'(e.val));
                end
            end
        end
        req_prev <= eng_req_o;
    end

    int run_cycles;
    task automatic run_to_done();
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
        run_cycles = 1;
        while (!done_o && run_cycles < 20000) begin
            @(negedge clk);
            run_cycles++;
        end
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check(!busy_o && !done_o && !pass_o && !err_o, "R11 status idle", int'({busy_o, done_o, pass_o, err_o}), 0);
        check(!tx_rst_o && !rx_rst_o && !eng_req_o && !eng_rst_o, "R11 controls low",
              int'({tx_rst_o, rx_rst_o, eng_req_o, eng_rst_o}), 0);
        check(cur_prof_o == 0 && fec_en_o, "R8 power-up profile", int'({fec_en_o, cur_prof_o}), 8);

        // run A: all good, PLL late
        push_run(9);
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
        repeat (10) @(negedge clk);
        check(busy_o == 1, "R1 busy while PLL unlocked", int'(busy_o), 1);
        check(engrst_cycles == 0 && !tx_rst_o, "R1 nothing before lock", engrst_cycles, 0);
        pll_lock_i = 1;
        run_cycles = 0;
        while (!done_o && run_cycles < 20000) begin
            @(negedge clk);
            run_cycles++;
        end
        check(engrst_cycles == 1, "R1 engine reset one cycle", engrst_cycles, 1);
        check(done_o && !busy_o, "R10 done after list", int'({done_o, busy_o}), 2);
        check(pass_o && !err_o, "R10 clean pass", int'({pass_o, err_o}), 2);
        check(exp_q.size() == 0, "R8 all profiles visited (R5 low-rate PCS skipped)", exp_q.size(), 0);
        check(cur_prof_o == 0 && fec_en_o, "R8 returns to power-up profile", int'({fec_en_o, cur_prof_o}), 8);

        // run B: checker fails on profile 3, list continues
        fail_id = 3;
        push_run(9);
        run_to_done();
        check(exp_q.size() == 0, "R7 list continues after bad verdict", exp_q.size(), 0);
        check(err_o && !pass_o, "R7 verdict sets error", int'({pass_o, err_o}), 1);
        fail_id = 7;

        // run C: receive reset ack never arrives
        blk_rxack = 1;
        exp_q.delete();
        run_to_done();
        check(done_o && err_o && !pass_o, "R9 timeout ends run", int'({done_o, err_o, pass_o}), 6);
        check(run_cycles >= 40, "R9 waits the limit", run_cycles, 40);
        check(!tx_rst_o && !rx_rst_o, "R9 resets released", int'({tx_rst_o, rx_rst_o}), 0);
        check(exp_q.size() == 0, "R2 no request before rx ack", exp_q.size(), 0);
        blk_rxack = 0;

        // run D: PCS never ready; profile 1 needs it
        pcs_en = 0;
        push_run(0);
        run_to_done();
        check(err_o && done_o, "R5 PCS check on profile 1", int'({done_o, err_o}), 3);
        check(cur_prof_o == 1, "R4 rate applied before PCS wait", int'(cur_prof_o), 1);
        check(exp_q.size() == 0, "R5 stopped at profile 1", exp_q.size(), 0);
        pcs_en = 1;

        // run E: restart clears error
        push_run(9);
        run_to_done();
        check(pass_o && !err_o, "R10 restart clears error", int'({pass_o, err_o}), 2);
        check(exp_q.size() == 0, "R8 full list after restart", exp_q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule